// File: doc/BRIEF.md
# Floating-Point Overflow Result Selector

This block sits after the first execute stage of a floating-point unit and decides what happens to a result that may have overflowed. It handles single and double precision. Its inputs are the preliminary biased exponent, an exact overflow indication produced after rounding, the sign of the intermediate result, the rounding mode, a precision select, and the overflow-trap enable. Its outputs are a 64-bit result word with a write enable for the destination register, two sticky status flags (overflow and inexact), two sticky exception-register flags (exception pending and overflow cause), and a one-cycle request that asks the software support code to handle the operation.

When the trap is enabled, the block works from the preliminary exponent alone and is deliberately pessimistic. Any exponent close enough to the top of the range that significand growth or rounding could still overflow causes a bounce. The destination register is then left untouched and only the exception-register flags are raised. When the trap is disabled, the block acts only on the exact overflow indication. It writes a substitute value, either infinity or the largest finite number, chosen by the rounding mode and the sign, and it raises the overflow and inexact status flags. Every accepted input strobe produces its registered outputs exactly one cycle later.

Top module: `fpOvfSel`

## Requirements
- R1: A cycle with `inValid` high yields `outValid`, `result`, `destWe` and `bounce` on the next clock edge. In any cycle without a preceding strobe, `outValid`, `destWe` and `bounce` are 0 and `result` is all zeros.
- R2: With `ovfTrapEn` = 1, a bounce is raised when `prelimExp` is greater than or equal to the largest normal biased exponent minus one (253 for single, 2045 for double). Otherwise the pass-through value is written with `destWe` = 1. `ovfFinal` has no effect in this mode.
- R3: On a bounce, `destWe` is 0, `result` is zero, and `stOvf` and `stInexact` keep their previous values.
- R4: A bounce sets the sticky flags `excEx` and `excOfc`.
- R5: With `ovfTrapEn` = 0 and `ovfFinal` = 1, the substitute value is written with `destWe` = 1, and `stOvf` and `stInexact` are set.
- R6: With `ovfTrapEn` = 0 and `ovfFinal` = 0, `normResult` is passed through with `destWe` = 1. No flag changes and `prelimExp` has no effect.
- R7: `rndMode` 2'b00 (to nearest) substitutes infinity with the intermediate sign.
- R8: `rndMode` 2'b11 (towards zero) substitutes the largest finite magnitude with the intermediate sign.
- R9: `rndMode` 2'b01 (towards plus infinity) substitutes plus infinity for a positive result and the most negative finite value for a negative result.
- R10: `rndMode` 2'b10 (towards minus infinity) substitutes the largest positive finite value for a positive result and minus infinity for a negative result.
- R11: With `isDouble` = 0, the result occupies bits 31:0 and bits 63:32 are zero. The single-precision patterns are infinity 0x7F800000 and largest finite 0x7F7FFFFF. The double-precision patterns are infinity 0x7FF0000000000000 and largest finite 0x7FEFFFFFFFFFFFFF. The sign is in the top bit of each format.
- R12: The four flags are sticky. A `flagClr` pulse clears all of them at the next edge, and if a flag is set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input strobe |
| isDouble | input | 1 | 1 = double precision, 0 = single |
| prelimExp | input | 11 | Preliminary biased result exponent |
| ovfFinal | input | 1 | Exact overflow after rounding |
| resSign | input | 1 | Sign of the intermediate result |
| rndMode | input | 2 | Rounding mode (00 nearest, 01 +inf, 10 -inf, 11 zero) |
| ovfTrapEn | input | 1 | Overflow trap enable |
| normResult | input | 64 | Normally rounded result, used when there is no overflow |
| flagClr | input | 1 | Clears all sticky flags |
| outValid | output | 1 | Registered output strobe |
| result | output | 64 | Result word for the destination register |
| destWe | output | 1 | Destination write enable |
| bounce | output | 1 | Request to support code |
| stOvf | output | 1 | Sticky overflow status flag |
| stInexact | output | 1 | Sticky inexact status flag |
| excEx | output | 1 | Sticky exception-pending flag |
| excOfc | output | 1 | Sticky overflow-cause exception flag |

## Verification
The hardest situations to reach are the two edges of the pessimistic window. One is an exponent exactly one below the bounce threshold that still carries a true overflow indication, which must pass through unchanged. The other is the same exponent value judged against the other precision's limit. The stimulus drives each threshold value and its neighbour in both precisions, with `ovfFinal` held opposite to the expected outcome. It also issues a clear in the same cycle as a flag-setting overflow, so that the set-wins priority of the sticky flags is observed.

// File: rtl/fpOvfPkg.sv
package fpOvfPkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_UP   = 2'b01,
    RND_DOWN = 2'b10,
    RND_ZERO = 2'b11
  } rndMode_e;

  // Strobes from control to datapath, valid in the input cycle
  typedef struct packed {
    logic bounceStb;
    logic substStb;
    logic passStb;
    logic dbl;
  } ovfStb_t;
endpackage

// File: rtl/fpOvfPattern.sv
module fpOvfPattern #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic          sign,
  input  logic          useMax,
  output logic [EW+FW:0] word
);
  localparam logic [EW+FW-1:0] INF_MAG = {{EW{1'b1}}, {FW{1'b0}}};
  localparam logic [EW+FW-1:0] MAX_MAG = {{(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};

  assign word = {sign, useMax ? MAX_MAG : INF_MAG};
endmodule

// File: rtl/fpOvfCtrl.sv
module fpOvfCtrl
  import fpOvfPkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int SP_EXP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             isDouble,
  input  logic [EXP_W-1:0] prelimExp,
  input  logic             ovfFinal,
  input  logic             ovfTrapEn,
  input  logic             flagClr,
  output ovfStb_t          stb,
  output logic             outValid,
  output logic             destWe,
  output logic             bounce,
  output logic             stOvf,
  output logic             stInexact,
  output logic             excEx,
  output logic             excOfc
);
  localparam logic [EXP_W-1:0] DP_MAX_NORM = EXP_W'((1 << EXP_W) - 2);
  localparam logic [EXP_W-1:0] SP_MAX_NORM = EXP_W'((1 << SP_EXP_W) - 2);
  localparam logic [EXP_W-1:0] DP_THRESH   = DP_MAX_NORM - 1'b1;
  localparam logic [EXP_W-1:0] SP_THRESH   = SP_MAX_NORM - 1'b1;

  logic [EXP_W-1:0] thresh;
  logic             nearTop;

  assign thresh  = isDouble ? DP_THRESH : SP_THRESH;
  assign nearTop = prelimExp >= thresh;

  always_comb begin
    stb           = '0;
    stb.dbl       = isDouble;
    stb.bounceStb = inValid && ovfTrapEn && nearTop;
    stb.substStb  = inValid && !ovfTrapEn && ovfFinal;
    stb.passStb   = inValid && !stb.bounceStb && !stb.substStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      destWe    <= 1'b0;
      bounce    <= 1'b0;
      stOvf     <= 1'b0;
      stInexact <= 1'b0;
      excEx     <= 1'b0;
      excOfc    <= 1'b0;
    end else begin
      outValid  <= inValid;
      destWe    <= stb.substStb || stb.passStb;
      bounce    <= stb.bounceStb;
      stOvf     <= (stOvf && !flagClr) || stb.substStb;
      stInexact <= (stInexact && !flagClr) || stb.substStb;
      excEx     <= (excEx && !flagClr) || stb.bounceStb;
      excOfc    <= (excOfc && !flagClr) || stb.bounceStb;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.bounceStb, stb.substStb, stb.passStb})); // R1
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R1
  AST_BOUNCE_NEEDS_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    bounce |-> $past(ovfTrapEn)); // R2
  AST_BOUNCE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    bounce |-> !destWe); // R3
  AST_BOUNCE_SETS_EXC: assert property (@(posedge clk) disable iff (!rstN)
    bounce |-> (excEx && excOfc)); // R4
  AST_STATUS_EXACT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stOvf) |-> $past(inValid && !ovfTrapEn && ovfFinal)); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stInexact) && !$past(flagClr)) |-> stInexact); // R12
endmodule

// File: rtl/fpOvfData.sv
module fpOvfData
  import fpOvfPkg::*;
#(
  parameter int EXP_W     = 11,
  parameter int FRAC_W    = 52,
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ovfStb_t                   stb,
  input  logic                      resSign,
  input  logic [1:0]                rndMode,
  input  logic [EXP_W+FRAC_W:0]     normResult,
  output logic [EXP_W+FRAC_W:0]     result
);
  localparam int DATA_W   = 1 + EXP_W + FRAC_W;
  localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int NUM_PREC = 2;

  logic              useMax;
  logic [DATA_W-1:0] patWord [NUM_PREC];
  logic [DATA_W-1:0] passWord;
  logic [DATA_W-1:0] nextRes;

  always_comb begin
    case (rndMode_e'(rndMode))
      RND_NEAR: useMax = 1'b0;
      RND_ZERO: useMax = 1'b1;
      RND_UP:   useMax = resSign;
      default:  useMax = !resSign;
    endcase
  end

  // Index 0 = single precision, 1 = double precision
  for (genvar gi = 0; gi < NUM_PREC; gi++) begin : g_prec
    localparam int EW = (gi == 0) ? SP_EXP_W : EXP_W;
    localparam int FW = (gi == 0) ? SP_FRAC_W : FRAC_W;
    logic [EW+FW:0] word;
    fpOvfPattern #(.EW(EW), .FW(FW)) u_pat (
      .sign   (resSign),
      .useMax (useMax),
      .word   (word)
    );
    assign patWord[gi] = DATA_W'(word);
  end

  assign passWord = stb.dbl ? normResult
                            : {{(DATA_W-SP_W){1'b0}}, normResult[SP_W-1:0]};

  always_comb begin
    nextRes = '0;
    if (stb.substStb)     nextRes = patWord[stb.dbl ? 1 : 0];
    else if (stb.passStb) nextRes = passWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) result <= '0;
    else       result <= nextRes;
  end

  logic anyStb;
  assign anyStb = stb.substStb || stb.passStb || stb.bounceStb;

  AST_SP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(anyStb) && !$past(stb.dbl)) |-> (result[DATA_W-1:SP_W] == '0)); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !$past(anyStb) |-> (result == '0)); // R1
endmodule

// File: rtl/fpOvfSel.sv
module fpOvfSel
  import fpOvfPkg::*;
#(
  parameter int EXP_W     = 11,
  parameter int FRAC_W    = 52,
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  isDouble,
  input  logic [EXP_W-1:0]      prelimExp,
  input  logic                  ovfFinal,
  input  logic                  resSign,
  input  logic [1:0]            rndMode,
  input  logic                  ovfTrapEn,
  input  logic [EXP_W+FRAC_W:0] normResult,
  input  logic                  flagClr,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  destWe,
  output logic                  bounce,
  output logic                  stOvf,
  output logic                  stInexact,
  output logic                  excEx,
  output logic                  excOfc
);
  ovfStb_t stb;

  fpOvfCtrl #(.EXP_W(EXP_W), .SP_EXP_W(SP_EXP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .isDouble  (isDouble),
    .prelimExp (prelimExp),
    .ovfFinal  (ovfFinal),
    .ovfTrapEn (ovfTrapEn),
    .flagClr   (flagClr),
    .stb       (stb),
    .outValid  (outValid),
    .destWe    (destWe),
    .bounce    (bounce),
    .stOvf     (stOvf),
    .stInexact (stInexact),
    .excEx     (excEx),
    .excOfc    (excOfc)
  );

  fpOvfData #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SP_EXP_W(SP_EXP_W),
              .SP_FRAC_W(SP_FRAC_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .resSign    (resSign),
    .rndMode    (rndMode),
    .normResult (normResult),
    .result     (result)
  );

  AST_BOUNCE_ZERO_RES: assert property (@(posedge clk) disable iff (!rstN)
    bounce |-> (result == '0)); // R3
endmodule

// File: tb/fpOvfSel_tb.sv
module fpOvfSel_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, isDouble = 1'b0, ovfFinal = 1'b0, resSign = 1'b0;
  logic [10:0] prelimExp = '0;
  logic [1:0]  rndMode = 2'b00;
  logic        ovfTrapEn = 1'b0, flagClr = 1'b0;
  logic [63:0] normResult = '0;
  logic        outValid, destWe, bounce, stOvf, stInexact, excEx, excOfc;
  logic [63:0] result;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpOvfSel u_dut (.*);

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic        bnc;
    logic [3:0]  flags;
    string       tag;
  } item_t;

  item_t sbq[$];
  logic [3:0] mFlags = '0; // {excEx, excOfc, stOvf, stInexact}

  function automatic logic [63:0] substVal(logic dbl, logic sg, logic [1:0] rm);
    logic mx;
    case (rm)
      2'b00: mx = 1'b0;
      2'b11: mx = 1'b1;
      2'b01: mx = sg;
      default: mx = !sg;
    endcase
    if (dbl) return {sg, mx ? 63'h7FEF_FFFF_FFFF_FFFF : 63'h7FF0_0000_0000_0000};
    else     return {32'h0, sg, mx ? 31'h7F7F_FFFF : 31'h7F80_0000};
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic drive(input logic dbl, input logic [10:0] pe, input logic of,
                       input logic sg, input logic [1:0] rm, input logic en,
                       input logic [63:0] nr, input logic clr, input string tag);
    item_t it;
    int thr;
    @(negedge clk);
    inValid = 1; isDouble = dbl; prelimExp = pe; ovfFinal = of; resSign = sg;
    rndMode = rm; ovfTrapEn = en; normResult = nr; flagClr = clr;
    if (clr) mFlags = '0;
    thr = dbl ? 2045 : 253;
    it.bnc = 0; it.we = 1; it.tag = tag;
    if (en && int'(pe) >= thr) begin
      it.bnc = 1; it.we = 0; it.res = '0; mFlags[3:2] = 2'b11;
    end else if (!en && of) begin
      it.res = substVal(dbl, sg, rm); mFlags[1:0] = 2'b11;
    end else begin
      it.res = dbl ? nr : {32'h0, nr[31:0]};
    end
    it.flags = mFlags;
    sbq.push_back(it);
    @(negedge clk);
    inValid = 0; flagClr = 0;
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbq.size() == 0) check(0, "R1", "outValid with empty scoreboard");
      else begin
        item_t e;
        e = sbq.pop_front();
        check(result == e.res && destWe == e.we && bounce == e.bnc &&
              {excEx, excOfc, stOvf, stInexact} == e.flags, e.tag,
              $sformatf("act res=%h we=%b bnc=%b fl=%b exp res=%h we=%b bnc=%b fl=%b",
                        result, destWe, bounce, {excEx, excOfc, stOvf, stInexact},
                        e.res, e.we, e.bnc, e.flags));
      end
    end
  end

  task automatic checkIdle(input string tag);
    @(negedge clk);
    check(!outValid && !destWe && !bounce && result == '0, tag,
          $sformatf("idle act v=%b we=%b bnc=%b res=%h exp 0/0/0/0",
                    outValid, destWe, bounce, result));
  endtask

  task automatic clearFlags();
    @(negedge clk);
    flagClr = 1; mFlags = '0;
    @(negedge clk);
    flagClr = 0;
    check({excEx, excOfc, stOvf, stInexact} == 4'b0, "R12",
          $sformatf("after clear act %b exp 0000", {excEx, excOfc, stOvf, stInexact}));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!outValid && !destWe && !bounce && result == '0 &&
          {excEx, excOfc, stOvf, stInexact} == 4'b0, "R1",
          "reset state act nonzero exp all zero");
    // R2: trap-enabled pessimistic window, single precision
    drive(0, 11'd100, 0, 0, 2'b00, 1, 64'hDEAD_BEEF_1234_5678, 0, "R2 sp pass R11");
    drive(0, 11'd252, 1, 1, 2'b00, 1, 64'h0000_0000_4000_0000, 0, "R2 sp below thr ovfFinal ignored");
    drive(0, 11'd253, 0, 0, 2'b00, 1, 64'h1111, 0, "R2 R3 R4 sp thr-1 bounce");
    drive(0, 11'd254, 0, 1, 2'b11, 1, 64'h2222, 0, "R2 R3 sp max bounce");
    checkIdle("R1 idle after bounce");
    clearFlags();
    // double precision edges
    drive(1, 11'd253, 0, 0, 2'b00, 1, 64'hC000_0000_0000_0001, 0, "R2 dp exp 253 pass");
    drive(1, 11'd2044, 1, 0, 2'b01, 1, 64'h7FE0_0000_0000_0000, 0, "R2 dp below thr");
    drive(1, 11'd2045, 0, 1, 2'b10, 1, 64'h3333, 0, "R2 R4 dp thr bounce");
    clearFlags();
    // R6: disabled, no overflow
    drive(0, 11'd254, 0, 1, 2'b00, 0, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R6 sp no ovf");
    drive(1, 11'd2046, 0, 0, 2'b11, 0, 64'h1234_5678_9ABC_DEF0, 0, "R6 dp no ovf");
    // R5 with R7..R10 in both precisions and signs
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          drive(p[0], 11'd0, 1, s[0], m[1:0], 0, 64'h5555_5555_5555_5555, 0,
                $sformatf("R5 R%0d R11 p=%0d s=%0d", (m == 0) ? 7 : (m == 3) ? 8 : (m == 1) ? 9 : 10, p, s));
    drive(0, 11'd10, 1, 0, 2'b01, 0, 64'h0, 0, "R9 sp pos inf");
    drive(0, 11'd10, 1, 1, 2'b10, 0, 64'h0, 0, "R10 sp neg inf");
    // R3: status flags unchanged by bounce
    clearFlags();
    drive(0, 11'd255, 0, 0, 2'b00, 1, 64'h0, 0, "R3 bounce leaves status");
    // R12: clear and set in same cycle, set wins
    drive(1, 11'd5, 1, 0, 2'b11, 0, 64'h0, 1, "R12 R8 clear with set");
    checkIdle("R1 final idle");
    repeat (2) @(negedge clk);
    check(sbq.size() == 0, "R1", $sformatf("leftover act %0d exp 0", sbq.size()));
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule